// File: doc/BRIEF.md
# Single-Wire Bus Bit Receiver

This block listens to a pulse-width-coded single-wire control bus and recovers its bits and bytes. The line rests high. Every bit starts with a falling edge. The time the line then stays low says what the bit is, and the gap to the next falling edge closes the period. All timing is counted in ticks of a 32768 Hz enable, so one tick is about 30.5 µs. Every window limit is a programmable port, 10 bits wide by default.

The line first passes through a two-flop synchroniser, and then an edge detector. A free-running tick counter is cleared on each falling edge, and its value is captured on each rising edge.

While hunting, the block waits for a start bit: a long low followed by a total period inside a window. It then collects eight data bits, most significant bit first, followed by an end-of-message flag and an acknowledge bit. It hands out the byte with both flags as a one-cycle pulse. Any timing fault inside a frame drops the message, pulses an error output and returns to hunting.

Two strobes mark the points inside a bit where a follower would sample the line: the data point, and the acknowledge point. These are meant for a separate acknowledge driver.

Top module: `swb_bit_rx`

## Requirements
- R1: While reset is asserted, and on the first cycles after it, `byte_valid`, `rx_err`, `data_strobe` and `ack_strobe` are all 0.
- R2: A frame begins only after a start bit whose low time (counted in ticks) lies within [`lim_start_lo_min`, `lim_start_lo_max`] and whose total period lies within [`lim_start_tot_min`, `lim_start_tot_max`]. While hunting, a low outside the start window is ignored: no error and no byte.
- R3: Inside a frame, a low time within [`lim_one_lo_min`, `lim_one_lo_max`] is bit value 1, and a low time within [`lim_zero_lo_min`, `lim_zero_lo_max`] is bit value 0. The first 8 bits form `byte_data` with the first bit received in bit 7. The 9th bit is `byte_eom` and the 10th bit is `byte_ack`. All three are presented with a single-cycle `byte_valid` pulse.
- R4: After a byte whose end-of-message flag is 0, the next bit starts a new byte with no new start bit. After a byte whose flag is 1, the block hunts again, and further bits without a start bit cause neither a byte nor an error.
- R5: Inside a frame, a low time that falls in neither data window pulses `rx_err` for one cycle and drops the frame.
- R6: Inside a frame, once the current low time reaches `lim_err_lo`, `rx_err` pulses while the line is still low, and the frame is dropped.
- R7: A data bit whose total period is below `lim_bit_tot_min`, or a start bit whose total period lies outside its window, pulses `rx_err`.
- R8: A high time greater than `lim_bit_hi_max` ends the bit period. After the acknowledge bit this completes the byte without error. After any other bit of a frame, or after a start bit, it pulses `rx_err`.
- R9: Inside a frame, `data_strobe` pulses once per data or end-of-message bit, when the count since the falling edge reaches `pt_data_smp`. `ack_strobe` pulses once per acknowledge bit, when the count reaches `pt_ack_smp`. The two strobes never pulse together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle time-base enable at 32768 Hz |
| line_in | input | 1 | Bus line level, asynchronous |
| lim_start_lo_min | input | TW | Start bit minimum low time |
| lim_start_lo_max | input | TW | Start bit maximum low time |
| lim_start_tot_min | input | TW | Start bit minimum total period |
| lim_start_tot_max | input | TW | Start bit maximum total period |
| lim_one_lo_min | input | TW | Logic 1 minimum low time |
| lim_one_lo_max | input | TW | Logic 1 maximum low time |
| lim_zero_lo_min | input | TW | Logic 0 minimum low time |
| lim_zero_lo_max | input | TW | Logic 0 maximum low time |
| lim_bit_tot_min | input | TW | Data bit minimum total period |
| lim_bit_hi_max | input | TW | Maximum high time before the period ends |
| lim_err_lo | input | TW | In-frame low time that is flagged as an error |
| pt_data_smp | input | TW | Data sample point, in ticks after the falling edge |
| pt_ack_smp | input | TW | Acknowledge sample point, in ticks after the falling edge |
| byte_valid | output | 1 | One-cycle pulse: byte and flags valid |
| byte_data | output | DW | Received byte |
| byte_eom | output | 1 | End-of-message flag of the byte |
| byte_ack | output | 1 | Acknowledge bit of the byte |
| rx_err | output | 1 | One-cycle pulse on a timing violation |
| data_strobe | output | 1 | Data sample point pulse |
| ack_strobe | output | 1 | Acknowledge sample point pulse |

## Verification
The bench drives several kinds of traffic:
- A clean two-byte message with mixed bit values and both flag settings, which separates bit order and flag placement from the data itself.
- A single-byte message followed by stray bits, which shows that the end-of-message flag really closes the frame.
- Patterns that each break exactly one limit: a short start low, an in-between data low, a stuck-low, an over-long start period, a short data period, and a frame cut off by a long high. Each of these isolates one window check and shows that it causes an error only where it should.

The stuck-low case looks at `rx_err` before the line is released, which confirms that the error-low check acts during the low phase and not at the edge.

// File: rtl/swb_pkg.sv
package swb_pkg;
  // Kind of bit whose low phase has been classified but whose period is open.
  typedef enum logic [1:0] {
    PK_NONE  = 2'd0,
    PK_START = 2'd1,
    PK_ONE   = 2'd2,
    PK_ZERO  = 2'd3
  } pend_e;

  typedef enum logic {
    ST_HUNT  = 1'b0,
    ST_FRAME = 1'b1
  } rx_st_e;
endpackage

// File: rtl/swb_sync.sv
// Synchroniser chain for the line plus edge detection on its output.
module swb_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic level,
  output logic fall,
  output logic rise
);
  logic [SYNC_STAGES-1:0] chain_q, chain_n;
  logic                   last_q, last_n;

  always_comb begin
    chain_n = {chain_q[SYNC_STAGES-2:0], line_in};
    last_n  = chain_q[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      last_q  <= 1'b1;
    end else begin
      chain_q <= chain_n;
      last_q  <= last_n;
    end
  end

  assign level = chain_q[SYNC_STAGES-1];
  assign fall  = last_q & ~level;
  assign rise  = ~last_q & level;
endmodule

// File: rtl/swb_timer.sv
// Tick counter cleared on each falling edge; low time captured on each rising edge.
module swb_timer #(
  parameter int TW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          fall,
  input  logic          rise,
  output logic [TW-1:0] cnt,
  output logic [TW-1:0] low_len
);
  localparam logic [TW-1:0] CNT_SAT = {TW{1'b1}};

  logic [TW-1:0] cnt_q, cnt_n, low_q, low_n;

  always_comb begin
    cnt_n = cnt_q;
    if (fall)                           cnt_n = '0;
    else if (tick && (cnt_q != CNT_SAT)) cnt_n = cnt_q + 1'b1;
    low_n = rise ? cnt_q : low_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      low_q <= '0;
    end else begin
      cnt_q <= cnt_n;
      low_q <= low_n;
    end
  end

  assign cnt     = cnt_q;
  assign low_len = low_q;
endmodule

// File: rtl/swb_frame.sv
// Window checks, bit classification, frame assembly and sample strobes.
module swb_frame
  import swb_pkg::*;
#(
  parameter int TW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          level,
  input  logic          fall,
  input  logic          rise,
  input  logic [TW-1:0] cnt,
  input  logic [TW-1:0] low_len,
  input  logic [TW-1:0] st_lo_min,
  input  logic [TW-1:0] st_lo_max,
  input  logic [TW-1:0] st_tot_min,
  input  logic [TW-1:0] st_tot_max,
  input  logic [TW-1:0] one_lo_min,
  input  logic [TW-1:0] one_lo_max,
  input  logic [TW-1:0] zero_lo_min,
  input  logic [TW-1:0] zero_lo_max,
  input  logic [TW-1:0] bit_tot_min,
  input  logic [TW-1:0] bit_hi_max,
  input  logic [TW-1:0] err_lo,
  input  logic [TW-1:0] smp_pt,
  input  logic [TW-1:0] ack_pt,
  output logic          byte_valid,
  output logic [DW-1:0] byte_data,
  output logic          byte_eom,
  output logic          byte_ack,
  output logic          rx_err,
  output logic          data_strobe,
  output logic          ack_strobe
);
  localparam int            IW      = $clog2(DW + 2);
  localparam logic [IW-1:0] IDX_EOM = IW'(DW);
  localparam logic [IW-1:0] IDX_ACK = IW'(DW + 1);

  rx_st_e        st_q, st_n;
  pend_e         pend_q, pend_n;
  logic [IW-1:0] idx_q, idx_n;
  logic [DW-1:0] sh_q, sh_n, dat_q, dat_n;
  logic          eom_q, eom_n, feom_q, feom_n, fack_q, fack_n;
  logic          v_q, v_n, e_q, e_n, ds_q, ds_n, as_q, as_n;
  logic          take, fail, tend, bit_v;
  logic [TW-1:0] hi_len;
  logic [TW:0]   cnt_inc;

  assign hi_len  = cnt - low_len;
  assign cnt_inc = {1'b0, cnt} + 1'b1;
  assign bit_v   = (pend_q == PK_ONE);

  always_comb begin
    st_n = st_q; pend_n = pend_q; idx_n = idx_q; sh_n = sh_q; eom_n = eom_q;
    dat_n = dat_q; feom_n = feom_q; fack_n = fack_q;
    v_n = 1'b0; e_n = 1'b0; ds_n = 1'b0; as_n = 1'b0;
    take = 1'b0; fail = 1'b0; tend = 1'b0;

    // Period end by falling edge: check the total period of the open bit.
    if (fall) begin
      if (pend_q == PK_START) begin
        if ((cnt >= st_tot_min) && (cnt <= st_tot_max)) begin
          st_n  = ST_FRAME;
          idx_n = '0;
        end else begin
          fail = 1'b1;
        end
      end else if (pend_q != PK_NONE) begin
        if (cnt >= bit_tot_min) take = 1'b1;
        else                    fail = 1'b1;
      end
      pend_n = PK_NONE;
    // Low phase finished: classify it.
    end else if (rise) begin
      if (st_q == ST_HUNT) begin
        pend_n = ((cnt >= st_lo_min) && (cnt <= st_lo_max)) ? PK_START : PK_NONE;
      end else if ((cnt >= one_lo_min) && (cnt <= one_lo_max)) begin
        pend_n = PK_ONE;
      end else if ((cnt >= zero_lo_min) && (cnt <= zero_lo_max)) begin
        pend_n = PK_ZERO;
      end else begin
        fail = 1'b1;
      end
    // Period end by an over-long high phase.
    end else if (level && (pend_q != PK_NONE) && (hi_len > bit_hi_max)) begin
      pend_n = PK_NONE;
      if ((pend_q != PK_START) && (idx_q == IDX_ACK)) begin
        take = 1'b1;
        tend = 1'b1;
      end else begin
        fail = 1'b1;
      end
    // Stuck low inside a frame.
    end else if (!level && (st_q == ST_FRAME) && (cnt >= err_lo)) begin
      fail = 1'b1;
    end

    if (take) begin
      if (idx_q < IDX_EOM) begin
        sh_n  = {sh_q[DW-2:0], bit_v};
        idx_n = idx_q + 1'b1;
      end else if (idx_q == IDX_EOM) begin
        eom_n = bit_v;
        idx_n = idx_q + 1'b1;
      end else begin
        v_n    = 1'b1;
        dat_n  = sh_q;
        feom_n = eom_q;
        fack_n = bit_v;
        idx_n  = '0;
        if (eom_q || tend) st_n = ST_HUNT;
      end
    end

    if (fail) begin
      st_n   = ST_HUNT;
      pend_n = PK_NONE;
      e_n    = 1'b1;
    end

    if (tick && !fall && (st_q == ST_FRAME)) begin
      ds_n = (idx_q <= IDX_EOM) && (cnt_inc == {1'b0, smp_pt});
      as_n = (idx_q == IDX_ACK) && (cnt_inc == {1'b0, ack_pt});
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_HUNT; pend_q <= PK_NONE; idx_q <= '0; sh_q <= '0; eom_q <= 1'b0;
      dat_q <= '0; feom_q <= 1'b0; fack_q <= 1'b0;
      v_q <= 1'b0; e_q <= 1'b0; ds_q <= 1'b0; as_q <= 1'b0;
    end else begin
      st_q <= st_n; pend_q <= pend_n; idx_q <= idx_n; sh_q <= sh_n; eom_q <= eom_n;
      dat_q <= dat_n; feom_q <= feom_n; fack_q <= fack_n;
      v_q <= v_n; e_q <= e_n; ds_q <= ds_n; as_q <= as_n;
    end
  end

  assign byte_valid  = v_q;
  assign byte_data   = dat_q;
  assign byte_eom    = feom_q;
  assign byte_ack    = fack_q;
  assign rx_err      = e_q;
  assign data_strobe = ds_q;
  assign ack_strobe  = as_q;
endmodule

// File: rtl/swb_bit_rx.sv
module swb_bit_rx #(
  parameter int TW          = 10,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          line_in,
  input  logic [TW-1:0] lim_start_lo_min,
  input  logic [TW-1:0] lim_start_lo_max,
  input  logic [TW-1:0] lim_start_tot_min,
  input  logic [TW-1:0] lim_start_tot_max,
  input  logic [TW-1:0] lim_one_lo_min,
  input  logic [TW-1:0] lim_one_lo_max,
  input  logic [TW-1:0] lim_zero_lo_min,
  input  logic [TW-1:0] lim_zero_lo_max,
  input  logic [TW-1:0] lim_bit_tot_min,
  input  logic [TW-1:0] lim_bit_hi_max,
  input  logic [TW-1:0] lim_err_lo,
  input  logic [TW-1:0] pt_data_smp,
  input  logic [TW-1:0] pt_ack_smp,
  output logic          byte_valid,
  output logic [DW-1:0] byte_data,
  output logic          byte_eom,
  output logic          byte_ack,
  output logic          rx_err,
  output logic          data_strobe,
  output logic          ack_strobe
);
  logic          level, fall, rise;
  logic [TW-1:0] cnt, low_len;

  swb_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .line_in(line_in),
    .level(level), .fall(fall), .rise(rise)
  );

  swb_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .fall(fall), .rise(rise),
    .cnt(cnt), .low_len(low_len)
  );

  swb_frame #(.TW(TW), .DW(DW)) u_frame (
    .clk(clk), .rst_n(rst_n), .tick(tick), .level(level), .fall(fall), .rise(rise),
    .cnt(cnt), .low_len(low_len),
    .st_lo_min(lim_start_lo_min), .st_lo_max(lim_start_lo_max),
    .st_tot_min(lim_start_tot_min), .st_tot_max(lim_start_tot_max),
    .one_lo_min(lim_one_lo_min), .one_lo_max(lim_one_lo_max),
    .zero_lo_min(lim_zero_lo_min), .zero_lo_max(lim_zero_lo_max),
    .bit_tot_min(lim_bit_tot_min), .bit_hi_max(lim_bit_hi_max),
    .err_lo(lim_err_lo), .smp_pt(pt_data_smp), .ack_pt(pt_ack_smp),
    .byte_valid(byte_valid), .byte_data(byte_data), .byte_eom(byte_eom),
    .byte_ack(byte_ack), .rx_err(rx_err),
    .data_strobe(data_strobe), .ack_strobe(ack_strobe)
  );
endmodule

// File: rtl/swb_bit_rx_chk.sv
module swb_bit_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic byte_valid,
  input logic rx_err,
  input logic data_strobe,
  input logic ack_strobe
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (!byte_valid && !rx_err && !data_strobe && !ack_strobe)
        else $error("outputs active during reset");
    end
  end

  assert_valid_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> !byte_valid);

  assert_valid_no_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> !rx_err);

  assert_err_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err |=> !rx_err);

  assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({data_strobe, ack_strobe}));
endmodule

bind swb_bit_rx swb_bit_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .rx_err(rx_err),
  .data_strobe(data_strobe), .ack_strobe(ack_strobe)
);

// File: tb/swb_bit_rx_bench.sv
`timescale 1ns/1ps
module swb_bit_rx_bench;
  localparam int TW = 10;
  localparam int DW = 8;
  localparam int SLO_MIN = 115, SLO_MAX = 128, STOT_MIN = 141, STOT_MAX = 154;
  localparam int ONE_MIN = 13, ONE_MAX = 26, ZERO_MIN = 43, ZERO_MAX = 56;
  localparam int BTOT_MIN = 67, HI_MAX = 92, ERR_LO = 111, SMP = 34, ACKP = 15;
  localparam int CNT_SAT = 1023;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, tick, line_in;
  logic byte_valid, byte_eom, byte_ack, rx_err, data_strobe, ack_strobe;
  logic [DW-1:0] byte_data;

  swb_bit_rx u_swb_bit_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .line_in(line_in),
    .lim_start_lo_min(TW'(SLO_MIN)), .lim_start_lo_max(TW'(SLO_MAX)),
    .lim_start_tot_min(TW'(STOT_MIN)), .lim_start_tot_max(TW'(STOT_MAX)),
    .lim_one_lo_min(TW'(ONE_MIN)), .lim_one_lo_max(TW'(ONE_MAX)),
    .lim_zero_lo_min(TW'(ZERO_MIN)), .lim_zero_lo_max(TW'(ZERO_MAX)),
    .lim_bit_tot_min(TW'(BTOT_MIN)), .lim_bit_hi_max(TW'(HI_MAX)),
    .lim_err_lo(TW'(ERR_LO)), .pt_data_smp(TW'(SMP)), .pt_ack_smp(TW'(ACKP)),
    .byte_valid(byte_valid), .byte_data(byte_data), .byte_eom(byte_eom),
    .byte_ack(byte_ack), .rx_err(rx_err),
    .data_strobe(data_strobe), .ack_strobe(ack_strobe)
  );

  int checks = 0;
  int errors = 0;
  int err_cnt = 0, ds_cnt = 0, as_cnt = 0;
  logic [DW+1:0] got_q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // Tick generator: one cycle high out of every four.
  initial begin
    tick = 1'b0;
    forever begin
      repeat (3) @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  end

  // Behavioural reference: line delayed three clocks, counts in ticks.
  int m_s1, m_s2, m_sd, m_cnt, m_low, m_st, m_pend, m_idx, m_eom;
  int m_sh;
  int e_v, e_d, e_eom, e_ack, e_err, e_ds, e_as;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 1; m_s2 = 1; m_sd = 1; m_cnt = 0; m_low = 0;
      m_st = 0; m_pend = 0; m_idx = 0; m_eom = 0; m_sh = 0;
      e_v = 0; e_d = 0; e_eom = 0; e_ack = 0; e_err = 0; e_ds = 0; e_as = 0;
    end else begin
      bit f, r, lv, take, fail, tend, b;
      int hi, st_old, idx_old;
      f = (m_sd == 1) && (m_s2 == 0);
      r = (m_sd == 0) && (m_s2 == 1);
      lv = (m_s2 == 1);
      hi = m_cnt - m_low;
      b = (m_pend == 2);
      st_old = m_st; idx_old = m_idx;
      take = 0; fail = 0; tend = 0;
      e_v = 0; e_err = 0; e_ds = 0; e_as = 0;
      if (tick && !f && st_old == 1) begin
        if (idx_old <= DW && m_cnt + 1 == SMP) e_ds = 1;
        if (idx_old == DW + 1 && m_cnt + 1 == ACKP) e_as = 1;
      end
      if (f) begin
        if (m_pend == 1) begin
          if (m_cnt >= STOT_MIN && m_cnt <= STOT_MAX) begin m_st = 1; m_idx = 0; end
          else fail = 1;
        end else if (m_pend != 0) begin
          if (m_cnt >= BTOT_MIN) take = 1; else fail = 1;
        end
        m_pend = 0;
      end else if (r) begin
        if (st_old == 0) m_pend = (m_cnt >= SLO_MIN && m_cnt <= SLO_MAX) ? 1 : 0;
        else if (m_cnt >= ONE_MIN && m_cnt <= ONE_MAX) m_pend = 2;
        else if (m_cnt >= ZERO_MIN && m_cnt <= ZERO_MAX) m_pend = 3;
        else fail = 1;
      end else if (lv && m_pend != 0 && hi > HI_MAX) begin
        if (m_pend != 1 && idx_old == DW + 1) begin take = 1; tend = 1; end
        else fail = 1;
        m_pend = 0;
      end else if (!lv && st_old == 1 && m_cnt >= ERR_LO) begin
        fail = 1;
      end
      if (take) begin
        if (idx_old < DW) begin m_sh = ((m_sh << 1) | int'(b)) & ((1 << DW) - 1); m_idx++; end
        else if (idx_old == DW) begin m_eom = int'(b); m_idx++; end
        else begin
          e_v = 1; e_d = m_sh; e_eom = m_eom; e_ack = int'(b); m_idx = 0;
          if (m_eom == 1 || tend) m_st = 0;
        end
      end
      if (fail) begin m_st = 0; m_pend = 0; e_err = 1; end
      if (r) m_low = m_cnt;
      if (f) m_cnt = 0;
      else if (tick && m_cnt < CNT_SAT) m_cnt++;
      m_sd = m_s2; m_s2 = m_s1; m_s1 = int'(line_in);
    end
  end

  // Per-cycle comparison and event capture, away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      chk(byte_valid == e_v[0] && (!e_v[0] || (byte_data == e_d[DW-1:0] &&
          byte_eom == e_eom[0] && byte_ack == e_ack[0])),
          "R3", "byte output vs model", {byte_data, byte_eom, byte_ack, byte_valid},
          {e_d[DW-1:0], e_eom[0], e_ack[0], e_v[0]});
      chk(rx_err == e_err[0], "R5", "rx_err vs model", int'(rx_err), e_err);
      chk(data_strobe == e_ds[0] && ack_strobe == e_as[0], "R9", "strobes vs model",
          {data_strobe, ack_strobe}, {e_ds[0], e_as[0]});
      if (byte_valid) got_q.push_back({byte_data, byte_eom, byte_ack});
      if (rx_err) err_cnt++;
      if (data_strobe) ds_cnt++;
      if (ack_strobe) as_cnt++;
    end
  end

  task automatic wait_ticks(input int n);
    repeat (n) @(posedge tick);
  endtask

  task automatic send_bit(input int lo, input int hi);
    line_in = 1'b0;
    wait_ticks(lo);
    line_in = 1'b1;
    wait_ticks(hi);
  endtask

  task automatic send_start;
    send_bit(120, 25);
  endtask

  task automatic send_data(input bit v);
    if (v) send_bit(20, 60);
    else   send_bit(50, 30);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit eom, input bit ack);
    for (int i = 7; i >= 0; i--) send_data(b[i]);
    send_data(eom);
    send_data(ack);
  endtask

  task automatic go_idle;
    wait_ticks(150);
    repeat (8) @(negedge clk);
  endtask

  initial begin
    int q0, e0, d0, a0;
    rst_n = 1'b0;
    line_in = 1'b1;
    repeat (5) @(negedge clk);
    chk(!byte_valid && !rx_err && !data_strobe && !ack_strobe, "R1", "outputs in reset",
        {byte_valid, rx_err, data_strobe, ack_strobe}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!byte_valid && !rx_err && !data_strobe && !ack_strobe, "R1", "outputs after reset",
        {byte_valid, rx_err, data_strobe, ack_strobe}, 0);

    // Two-byte message, second byte closes it (R2 R3 R4 R8 R9).
    q0 = got_q.size(); e0 = err_cnt; d0 = ds_cnt; a0 = as_cnt;
    send_start;
    send_byte(8'h4F, 1'b0, 1'b1);
    send_byte(8'hA0, 1'b1, 1'b0);
    go_idle;
    chk(got_q.size() - q0 == 2, "R4", "bytes in two-byte message", got_q.size() - q0, 2);
    if (got_q.size() - q0 == 2) begin
      chk(got_q[q0] == {8'h4F, 1'b0, 1'b1}, "R3", "first byte and flags", int'(got_q[q0]),
          int'({8'h4F, 1'b0, 1'b1}));
      chk(got_q[q0+1] == {8'hA0, 1'b1, 1'b0}, "R3", "second byte and flags",
          int'(got_q[q0+1]), int'({8'hA0, 1'b1, 1'b0}));
    end
    chk(err_cnt == e0, "R8", "no error after final ack timeout", err_cnt - e0, 0);
    chk(ds_cnt - d0 == 18, "R9", "data strobes", ds_cnt - d0, 18);
    chk(as_cnt - a0 == 2, "R9", "ack strobes", as_cnt - a0, 2);

    // Short start low is ignored while hunting (R2).
    q0 = got_q.size(); e0 = err_cnt;
    send_bit(100, 45);
    send_byte(8'h3C, 1'b1, 1'b1);
    go_idle;
    chk(got_q.size() == q0, "R2", "no byte without valid start", got_q.size() - q0, 0);
    chk(err_cnt == e0, "R2", "no error while hunting", err_cnt - e0, 0);

    // Low between the data windows (R5).
    q0 = got_q.size(); e0 = err_cnt;
    send_start;
    send_data(1'b1); send_data(1'b0);
    send_bit(35, 45);
    go_idle;
    chk(err_cnt - e0 == 1, "R5", "error on unclassified low", err_cnt - e0, 1);
    chk(got_q.size() == q0, "R5", "frame dropped", got_q.size() - q0, 0);

    // Stuck low inside a frame reports before release (R6).
    e0 = err_cnt;
    send_start;
    send_data(1'b1);
    line_in = 1'b0;
    wait_ticks(113);
    chk(err_cnt - e0 == 1, "R6", "error while line still low", err_cnt - e0, 1);
    line_in = 1'b1;
    go_idle;
    chk(err_cnt - e0 == 1, "R6", "single error for stuck low", err_cnt - e0, 1);

    // Start period too long (R7).
    q0 = got_q.size(); e0 = err_cnt;
    send_bit(120, 40);
    send_byte(8'h81, 1'b1, 1'b0);
    go_idle;
    chk(err_cnt - e0 == 1, "R7", "error on long start period", err_cnt - e0, 1);
    chk(got_q.size() == q0, "R7", "no byte after bad start", got_q.size() - q0, 0);

    // Data bit period too short (R7).
    e0 = err_cnt;
    send_start;
    send_bit(20, 30);
    send_data(1'b0);
    go_idle;
    chk(err_cnt - e0 == 1, "R7", "error on short data period", err_cnt - e0, 1);

    // Frame cut off by a long high mid-byte (R8).
    q0 = got_q.size(); e0 = err_cnt;
    send_start;
    send_data(1'b1); send_data(1'b1); send_data(1'b0);
    go_idle;
    chk(err_cnt - e0 == 1, "R8", "error on mid-frame timeout", err_cnt - e0, 1);
    chk(got_q.size() == q0, "R8", "no byte after timeout", got_q.size() - q0, 0);

    // End-of-message closes the frame; stray bits follow (R4).
    q0 = got_q.size(); e0 = err_cnt;
    send_start;
    send_byte(8'h01, 1'b1, 1'b1);
    send_data(1'b1); send_data(1'b0);
    go_idle;
    chk(got_q.size() - q0 == 1, "R4", "one byte then hunt", got_q.size() - q0, 1);
    if (got_q.size() - q0 == 1)
      chk(got_q[q0] == {8'h01, 1'b1, 1'b1}, "R3", "single byte and flags", int'(got_q[q0]),
          int'({8'h01, 1'b1, 1'b1}));
    chk(err_cnt == e0, "R4", "stray bits after end of message", err_cnt - e0, 0);

    finish_run;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R1 watchdog: actual=running expected=finished");
    finish_run;
  end
endmodule